// File: doc/BRIEF.md
# Maskable interrupt latch controller

This block gathers interrupt requests from up to sixteen peripheral sources into one latch per source. Each latch stays set until software clears it or the core accepts it. A request can only come from hardware. A software write can lower a latch bit but can never raise one. A global interrupt-enable bit and one enable bit per source gate the maskable sources. Sources marked non-maskable skip every enable. A priority picker then presents one pending source and its index to the core.

The core answers with an accept pulse. The accept pulse clears the serviced latch, pushes the current global enable onto a small internal stack and drops the global enable. A return pulse pops the stack back into the global enable, which allows nested service. Set and clear strobes force the global enable directly. Software can read the latch and enable words, write the enable word, and clear latches through a two-address synchronous register port. The stack reports an overflow or an underflow on a one-cycle flag. Apart from that flag, the offending push or pop has no effect.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset all latches read 0, the enable word reads 0 (global enable off), and irq_pend, stk_ovf and stk_unf are 0.
- R2: A 1 on irq_req[i] sets latch i on the next clock edge if bit i is implemented (default: bits 15..1; bit 0 always reads 0). Writing 1s to the latch word (reg_addr 0) never sets a latch.
- R3: Writing the latch word clears each latch whose written bit is 0, except the protected latches 2 and 3, which a write cannot clear.
- R4: The enable word (reg_addr 1) is read and written as a whole. Bit 0 is the global enable and bit i (i ≥ 1) enables source i.
- R5: A maskable source is pending only when its latch, its own enable bit and the global enable are all 1.
- R6: Non-maskable sources (default 2 and 3) are pending whenever their latch is set, whatever the enable word holds.
- R7: Any pending non-maskable source beats every maskable one. Within a class the lowest index wins. irq_idx is 0 while nothing is pending.
- R8: cpu_ack while irq_pend clears the latch of the source shown on irq_idx. A request on the same latch in the same cycle wins over an accept clear and over a software clear.
- R9: An accepted cpu_ack saves the global enable and clears it. cpu_reti reloads it from the most recent saved value. cpu_ack while nothing is pending has no effect.
- R10: Saved values nest four deep and come back in last-in first-out order.
- R11: An accept with four saved values raises stk_ovf for one cycle and leaves the stack unchanged. A return with none saved raises stk_unf for one cycle and leaves the global enable unchanged.
- R12: Precedence on the global enable in one cycle, highest first: accept, return, clear strobe, set strobe, register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request pulses, one per source |
| reg_addr | input | 1 | 0 selects the latch word, 1 selects the enable word |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ei_strobe | input | 1 | Force the global enable to 1 |
| di_strobe | input | 1 | Force the global enable to 0 |
| cpu_ack | input | 1 | Core accepts the presented source |
| cpu_reti | input | 1 | Core returns from service |
| irq_pend | output | 1 | A source is eligible for service |
| irq_idx | output | 4 | Index of the presented source |
| stk_ovf | output | 1 | One-cycle flag: push on a full stack |
| stk_unf | output | 1 | One-cycle flag: pop on an empty stack |

## Verification
The bench uses the default parameters: sixteen sources, sources 2 and 3 both non-maskable and protected from software clears, and a stack four entries deep. Because the stack is that shallow, five nested accepts on a non-maskable source reach the overflow corner, and a fifth return reaches the underflow corner. Because the protected, non-maskable pair sits between maskable sources, one vector walk covers the priority crossing between classes, the refused software clear, and the clear by accept.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam logic REG_SEL_LATCH  = 1'b0;
    localparam logic REG_SEL_ENABLE = 1'b1;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int          NSRC       = 16,
    parameter logic [15:0] LATCH_MASK = 16'hFFFE,
    parameter logic [15:0] NOCLR_MASK = 16'h000C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            sw_wr,
    input  logic [NSRC-1:0] sw_data,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] lat_q
);
    localparam logic [NSRC-1:0] LMASK = LATCH_MASK[NSRC-1:0];
    localparam logic [NSRC-1:0] PMASK = NOCLR_MASK[NSRC-1:0];

    typedef struct packed {
        logic [NSRC-1:0] lat;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] sw_clr;

    always_comb begin
        st_d   = st_q;
        sw_clr = sw_wr ? (~sw_data & ~PMASK) : '0;
        // a new request outranks every clear in the same cycle
        st_d.lat = ((st_q.lat & ~sw_clr & ~ack_clr) | req) & LMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_q = st_q.lat;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NSRC-1:0] wdata,
    input  logic            take,
    input  logic            ret,
    input  logic            stk_empty,
    input  logic            stk_top,
    input  logic            ei,
    input  logic            di,
    output logic [NSRC-1:0] en_q
);
    typedef struct packed {
        logic [NSRC-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.en = wdata;
        // global enable in bit 0; ordered lowest to highest precedence
        if (ei) st_d.en[0] = 1'b1;
        if (di) st_d.en[0] = 1'b0;
        if (ret && !stk_empty) st_d.en[0] = stk_top;
        if (ret && stk_empty)  st_d.en[0] = st_q.en[0];
        if (take) st_d.en[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/irq_imf_stack.sv
module irq_imf_stack #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_val,
    input  logic pop,
    output logic top_val,
    output logic empty,
    output logic ovf_q,
    output logic unf_q
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic [CW-1:0]    cnt;
        logic             ovf;
        logic             unf;
    } st_t;

    st_t st_d, st_q;
    logic full;

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        top_val = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == st_q.cnt) top_val = st_q.bits[i];
        end

        st_d     = st_q;
        st_d.ovf = push && full;
        st_d.unf = pop && !push && empty;
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_q.cnt) st_d.bits[i] = push_val;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !push && !empty) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_q = st_q.ovf;
    assign unf_q = st_q.unf;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int          NSRC     = 16,
    parameter logic [15:0] NMI_MASK = 16'h000C,
    localparam int         IW       = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] lat,
    input  logic [NSRC-1:0] en,
    output logic            pend,
    output logic [IW-1:0]   idx
);
    localparam logic [NSRC-1:0] NMASK = NMI_MASK[NSRC-1:0];

    logic [NSRC-1:0] nmi_v, msk_v;

    always_comb begin
        nmi_v = lat & NMASK;
        msk_v = lat & ~NMASK & en & {NSRC{en[0]}};
        pend  = (nmi_v != '0) || (msk_v != '0);
        idx   = '0;
        if (nmi_v != '0) begin
            for (int i = NSRC - 1; i >= 0; i--)
                if (nmi_v[i]) idx = IW'(i);
        end else begin
            for (int i = NSRC - 1; i >= 0; i--)
                if (msk_v[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter int          NSRC       = 16,
    parameter int          DEPTH      = 4,
    parameter logic [15:0] LATCH_MASK = 16'hFFFE,
    parameter logic [15:0] NMI_MASK   = 16'h000C,
    parameter logic [15:0] NOCLR_MASK = 16'h000C,
    localparam int         IW         = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_req,
    input  logic            reg_addr,
    input  logic            reg_wen,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic            ei_strobe,
    input  logic            di_strobe,
    input  logic            cpu_ack,
    input  logic            cpu_reti,
    output logic            irq_pend,
    output logic [IW-1:0]   irq_idx,
    output logic            stk_ovf,
    output logic            stk_unf
);
    import irq_pkg::*;

    logic [NSRC-1:0] lat_q, en_q, ack_clr;
    logic            take, ret, stk_top, stk_empty;

    always_comb begin
        take    = cpu_ack && irq_pend;
        ret     = cpu_reti && !take;
        ack_clr = take ? ({{(NSRC-1){1'b0}}, 1'b1} << irq_idx) : '0;
        reg_rdata = (reg_addr == REG_SEL_ENABLE) ? en_q : lat_q;
    end

    irq_latch_bank #(.NSRC(NSRC), .LATCH_MASK(LATCH_MASK), .NOCLR_MASK(NOCLR_MASK)) u_lat (
        .clk(clk), .rst_n(rst_n), .req(irq_req),
        .sw_wr(reg_wen && reg_addr == REG_SEL_LATCH), .sw_data(reg_wdata),
        .ack_clr(ack_clr), .lat_q(lat_q)
    );

    irq_enable_reg #(.NSRC(NSRC)) u_en (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wen && reg_addr == REG_SEL_ENABLE), .wdata(reg_wdata),
        .take(take), .ret(ret), .stk_empty(stk_empty), .stk_top(stk_top),
        .ei(ei_strobe), .di(di_strobe), .en_q(en_q)
    );

    irq_imf_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(take), .push_val(en_q[0]),
        .pop(ret), .top_val(stk_top), .empty(stk_empty),
        .ovf_q(stk_ovf), .unf_q(stk_unf)
    );

    irq_arbiter #(.NSRC(NSRC), .NMI_MASK(NMI_MASK)) u_arb (
        .lat(lat_q), .en(en_q), .pend(irq_pend), .idx(irq_idx)
    );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
    parameter int          NSRC       = 16,
    parameter logic [15:0] LATCH_MASK = 16'hFFFE,
    parameter logic [15:0] NMI_MASK   = 16'h000C,
    parameter logic [15:0] NOCLR_MASK = 16'h000C,
    localparam int         IW         = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] req,
    input logic            ack,
    input logic            pend,
    input logic [IW-1:0]   idx,
    input logic [NSRC-1:0] lat,
    input logic            imf,
    input logic            ovf
);
    localparam logic [NSRC-1:0] LM = LATCH_MASK[NSRC-1:0];
    localparam logic [NSRC-1:0] NM = NMI_MASK[NSRC-1:0];
    localparam logic [NSRC-1:0] PM = NOCLR_MASK[NSRC-1:0];

    // R2
    req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & LM) != '0) |=> ((lat & $past(req & LM)) == $past(req & LM)));

    // R3
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack && pend) |-> ((($past(lat) & ~lat) & PM) == '0));

    // R5
    mask_imf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !NM[idx]) |-> imf);

    // R6
    nmi_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat & NM) != '0) |-> (pend && NM[idx]));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend && !req[idx]) |=> !lat[$past(idx)]);

    // R9
    ack_imf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend) |=> !imf);

    // R11
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(ack && pend));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
    .NSRC(NSRC), .LATCH_MASK(LATCH_MASK), .NMI_MASK(NMI_MASK), .NOCLR_MASK(NOCLR_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .ack(cpu_ack), .pend(irq_pend),
    .idx(irq_idx), .lat(lat_q), .imf(en_q[0]), .ovf(stk_ovf)
);

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        reg_addr = 1'b0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ei_strobe = 1'b0, di_strobe = 1'b0, cpu_ack = 1'b0, cpu_reti = 1'b0;
    logic        irq_pend;
    logic [3:0]  irq_idx;
    logic        stk_ovf, stk_unf;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_latch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ei_strobe(ei_strobe), .di_strobe(di_strobe), .cpu_ack(cpu_ack),
        .cpu_reti(cpu_reti), .irq_pend(irq_pend), .irq_idx(irq_idx),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    typedef struct packed {
        logic [15:0] req;
        logic        wen;
        logic        addr;
        logic [15:0] wdata;
        logic        ack;
        logic        reti;
        logic        ei;
        logic        di;
        logic [15:0] e_lat;
        logic [15:0] e_en;
        logic        e_pend;
        logic [3:0]  e_idx;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{16'h0030, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0030, 16'h0000, 1'b0, 4'd0, 8'd5},
        '{16'h0000, 1'b1, 1'b1, 16'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0030, 16'h0020, 1'b0, 4'd0, 8'd5},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0030, 16'h0021, 1'b1, 4'd5, 8'd5},
        '{16'h0000, 1'b1, 1'b1, 16'h0031, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0030, 16'h0031, 1'b1, 4'd4, 8'd7},
        '{16'h0008, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0038, 16'h0031, 1'b1, 4'd3, 8'd7},
        '{16'h0000, 1'b1, 1'b0, 16'hFFE7, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0028, 16'h0031, 1'b1, 4'd3, 8'd3},
        '{16'h0001, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0028, 16'h0031, 1'b1, 4'd3, 8'd2},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0028, 16'h0030, 1'b1, 4'd3, 8'd6},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0020, 16'h0030, 1'b0, 4'd0, 8'd8},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0020, 16'h0031, 1'b1, 4'd5, 8'd12},
        '{16'h0020, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0020, 16'h0030, 1'b0, 4'd0, 8'd8},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0020, 16'h0031, 1'b1, 4'd5, 8'd9},
        '{16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0020, 16'h0030, 1'b0, 4'd0, 8'd9},
        '{16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0030, 1'b0, 4'd0, 8'd3}
    };

    task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle();
        irq_req = '0; reg_wen = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        ei_strobe = 1'b0; di_strobe = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0;
    endtask

    // apply the driven inputs for one edge, then release them
    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    function automatic string rtag(input logic [7:0] n);
        return $sformatf("R%0d", n);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1", "latch", v, 16'h0000);
        rd(1'b1, v); chk("R1", "enable", v, 16'h0000);
        chk("R1", "pend/ovf/unf", {13'd0, irq_pend, stk_ovf, stk_unf}, 16'h0000);

        // vector walk: R2 R3 R5 R6 R7 R8 R9 R12
        for (int k = 0; k < NV; k++) begin
            irq_req = VEC[k].req; reg_wen = VEC[k].wen; reg_addr = VEC[k].addr;
            reg_wdata = VEC[k].wdata; cpu_ack = VEC[k].ack; cpu_reti = VEC[k].reti;
            ei_strobe = VEC[k].ei; di_strobe = VEC[k].di;
            step();
            chk(rtag(VEC[k].rq), $sformatf("v%0d pend", k), {15'd0, irq_pend}, {15'd0, VEC[k].e_pend});
            chk(rtag(VEC[k].rq), $sformatf("v%0d idx", k), {12'd0, irq_idx}, {12'd0, VEC[k].e_idx});
            rd(1'b0, v); chk(rtag(VEC[k].rq), $sformatf("v%0d latch", k), v, VEC[k].e_lat);
            rd(1'b1, v); chk(rtag(VEC[k].rq), $sformatf("v%0d enable", k), v, VEC[k].e_en);
        end

        // R4 enable word round trip
        reg_wen = 1'b1; reg_addr = 1'b1; reg_wdata = 16'hA5A4; step();
        rd(1'b1, v); chk("R4", "enable rw", v, 16'hA5A4);
        reg_wen = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0001; step();
        rd(1'b1, v); chk("R4", "enable global bit", v, 16'h0001);

        // R10 four nested accepts on non-maskable source 2
        for (int k = 0; k < 4; k++) begin
            irq_req = 16'h0004; step();
            chk("R6", "nmi pend", {12'd0, irq_idx}, 16'd2);
            cpu_ack = 1'b1; step();
            rd(1'b1, v); chk("R10", "global cleared on accept", {15'd0, v[0]}, 16'd0);
            rd(1'b0, v); chk("R8", "accept clears latch 2", v, 16'h0000);
            chk("R11", "no ovf", {15'd0, stk_ovf}, 16'd0);
        end
        // R11 fifth accept overflows
        irq_req = 16'h0004; step();
        cpu_ack = 1'b1; step();
        chk("R11", "ovf pulse", {15'd0, stk_ovf}, 16'd1);
        step();
        chk("R11", "ovf one cycle", {15'd0, stk_ovf}, 16'd0);
        // R10 unwind: expect 0,0,0,1
        for (int k = 0; k < 4; k++) begin
            cpu_reti = 1'b1; step();
            rd(1'b1, v);
            chk("R10", $sformatf("pop %0d", k), {15'd0, v[0]}, (k == 3) ? 16'd1 : 16'd0);
            chk("R11", "no unf", {15'd0, stk_unf}, 16'd0);
        end
        // R11 underflow keeps global enable
        cpu_reti = 1'b1; step();
        chk("R11", "unf pulse", {15'd0, stk_unf}, 16'd1);
        rd(1'b1, v); chk("R11", "global kept on unf", {15'd0, v[0]}, 16'd1);

        // R9 accept with nothing pending is ignored
        cpu_ack = 1'b1; step();
        rd(1'b1, v); chk("R9", "idle accept ignored", v, 16'h0001);

        // R12 clear strobe beats set strobe; set strobe beats register write
        ei_strobe = 1'b1; di_strobe = 1'b1; step();
        rd(1'b1, v); chk("R12", "di over ei", v, 16'h0000);
        ei_strobe = 1'b1; reg_wen = 1'b1; reg_addr = 1'b1; reg_wdata = 16'h0080; step();
        rd(1'b1, v); chk("R12", "ei over write", v, 16'h0081);

        // R8 request beats a software clear in the same cycle
        irq_req = 16'h0080; reg_wen = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0000; step();
        rd(1'b0, v); chk("R8", "req over sw clear", v, 16'h0080);
        chk("R5", "enabled maskable pending", {11'd0, irq_pend, irq_idx}, 16'h0017);
        reg_wen = 1'b1; reg_addr = 1'b0; reg_wdata = 16'hFF7F; step();
        rd(1'b0, v); chk("R3", "sw clear bit 7", v, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule